// File: doc/BRIEF.md
# Chip-Select-Gated Configurable Registered Buffer

This block is a bank of clocked registers placed between a memory controller and the memory devices on a buffered module. On each rising clock edge it captures address and command bits and drives them back out. Two configuration inputs choose how the bank is organised. In the wide mode each active input bit drives a single output. In the narrow mode each captured bit drives two identical copies, an A copy and a B copy. The narrow mode also has two lane subsets, and the second configuration input picks which one is used.

Two active-low select inputs control the data outputs. When both selects are high at a clock edge, the data outputs are frozen. Three control bits are always registered, whatever the selects do: clock enable, termination control and a chip-select copy. An active-low asynchronous reset clears every register at once. The configuration inputs are static and are only changed while reset is held. The block moves no stream of data, so it has no valid/ready handshake. Every pin is a plain level signal that is sampled on each edge.

Top module: `sbuf_cs_gated`

## Requirements
- R1: While `rst_n` is low, every output is 0. This takes effect without waiting for a clock edge.
- R2: Data is captured on the rising edge of `clk`. The outputs show the value captured at the most recent edge.
- R3: If `sel_dev_n` and `sel_rank_n` are both 1 at an edge, `q_a` and `q_b` keep their previous values.
- R4: If either select input is 0 at an edge, the active data lanes load `d_in` at that edge.
- R5: `cke_a`, `odt_a` and `cs_a` load `cke_in`, `odt_in` and `sel_dev_n` at every edge, even when the data outputs are frozen.
- R6: Lane n (numbered from 1) is `d_in[n-1]`. With `cfg_narrow`=0 (wide mode), the active lanes are 2, 3, 5, 6 and 8 to 25. Lanes that are not active always output 0.
- R7: In wide mode, `q_b`, `cke_b`, `odt_b` and `cs_b` stay at 0.
- R8: With `cfg_narrow`=1 and `cfg_bsel`=0, the active lanes are 2, 3, 5, 6 and 8 to 14.
- R9: With `cfg_narrow`=1 and `cfg_bsel`=1, the active lanes are 1 to 6, 8 to 10, 12 and 13. In narrow mode, each B output equals its A output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_narrow | input | 1 | 0: wide 1:1 mode; 1: narrow 1:2 mode |
| cfg_bsel | input | 1 | Lane subset select in narrow mode |
| sel_dev_n | input | 1 | Active-low select; also registered to the chip-select copies |
| sel_rank_n | input | 1 | Second active-low select |
| d_in | input | 25 | Data lanes; lane n is bit n-1 |
| cke_in | input | 1 | Clock-enable input |
| odt_in | input | 1 | Termination-control input |
| q_a | output | 25 | Registered data, A copy |
| q_b | output | 25 | Registered data, B copy |
| cke_a | output | 1 | Registered clock enable, A copy |
| cke_b | output | 1 | Registered clock enable, B copy |
| odt_a | output | 1 | Registered termination control, A copy |
| odt_b | output | 1 | Registered termination control, B copy |
| cs_a | output | 1 | Registered chip select, A copy |
| cs_b | output | 1 | Registered chip select, B copy |

## Verification
The state of this block is simply the captured data and control registers. A wrong load enable shows at the ports one edge later. It appears either as a stale value while a select is low, or as a data change while both selects are high. A wrong lane mask shows as a nonzero value on an inactive lane, or as a missing bit on an active lane, at the first edge in that configuration. A wrong B-copy gate shows as a mismatch between `q_a` and `q_b`, or as a nonzero B output in wide mode.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int LANES = 25;

  typedef enum logic [1:0] {
    MODE_WIDE    = 2'b00,
    MODE_NARROW_A = 2'b10,
    MODE_NARROW_B = 2'b11
  } sbuf_mode_e;

  // lane numbers are 1-based; returns whether that lane is used in the mode
  function automatic logic lane_used(input int lane, input logic narrow, input logic bsel);
    logic r;
    if (!narrow)
      r = (lane >= 1) && (lane <= 25) && (lane != 1) && (lane != 4) && (lane != 7);
    else if (!bsel)
      r = (lane >= 2) && (lane <= 14) && (lane != 4) && (lane != 7);
    else
      r = ((lane >= 1) && (lane <= 6)) || (lane == 8) || (lane == 9) ||
          (lane == 10) || (lane == 12) || (lane == 13);
    return r;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic narrow, input logic bsel);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = lane_used(i + 1, narrow, bsel);
    return m;
  endfunction
endpackage

// File: rtl/sbuf_mask_gen.sv
module sbuf_mask_gen
  import sbuf_pkg::*;
#(
  parameter int W = LANES
) (
  input  logic         narrow,
  input  logic         bsel,
  output logic [W-1:0] mask
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    localparam logic IN_WIDE = lane_used(i + 1, 1'b0, 1'b0);
    localparam logic IN_NA   = lane_used(i + 1, 1'b1, 1'b0);
    localparam logic IN_NB   = lane_used(i + 1, 1'b1, 1'b1);
    always_comb begin
      unique case ({narrow, bsel})
        2'b10:   mask[i] = IN_NA;
        2'b11:   mask[i] = IN_NB;
        default: mask[i] = IN_WIDE;
      endcase
    end
  end
endmodule

// File: rtl/sbuf_data_bank.sv
module sbuf_data_bank #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dup,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] d,
  output logic [W-1:0] qa,
  output logic [W-1:0] qb
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= d & mask;
  end

  assign qa = held;
  assign qb = dup ? held : '0;
endmodule

// File: rtl/sbuf_ctl_bank.sv
module sbuf_ctl_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dup,
  input  logic [N-1:0] d,
  output logic [N-1:0] qa,
  output logic [N-1:0] qb
);
  logic [N-1:0] r;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r[i] <= 1'b0;
      else        r[i] <= d[i];
    end
    assign qa[i] = r[i];
    assign qb[i] = dup & r[i];
  end
endmodule

// File: rtl/sbuf_cs_gated.sv
module sbuf_cs_gated
  import sbuf_pkg::*;
#(
  parameter int W = LANES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_narrow,
  input  logic         cfg_bsel,
  input  logic         sel_dev_n,
  input  logic         sel_rank_n,
  input  logic [W-1:0] d_in,
  input  logic         cke_in,
  input  logic         odt_in,
  output logic [W-1:0] q_a,
  output logic [W-1:0] q_b,
  output logic         cke_a,
  output logic         cke_b,
  output logic         odt_a,
  output logic         odt_b,
  output logic         cs_a,
  output logic         cs_b
);
  localparam int NCTL = 3;

  logic [W-1:0]    mask;
  logic            load;
  logic [NCTL-1:0] ctl_d, ctl_a, ctl_b;

  assign load  = ~(sel_dev_n & sel_rank_n);
  assign ctl_d = {sel_dev_n, odt_in, cke_in};

  sbuf_mask_gen #(.W(W)) u_mask (
    .narrow(cfg_narrow), .bsel(cfg_bsel), .mask(mask)
  );

  sbuf_data_bank #(.W(W)) u_data (
    .clk(clk), .rst_n(rst_n), .load(load), .dup(cfg_narrow),
    .mask(mask), .d(d_in), .qa(q_a), .qb(q_b)
  );

  sbuf_ctl_bank #(.N(NCTL)) u_ctl (
    .clk(clk), .rst_n(rst_n), .dup(cfg_narrow),
    .d(ctl_d), .qa(ctl_a), .qb(ctl_b)
  );

  assign {cs_a, odt_a, cke_a} = ctl_a;
  assign {cs_b, odt_b, cke_b} = ctl_b;
endmodule

// File: rtl/sbuf_cs_gated_chk.sv
module sbuf_cs_gated_chk
  import sbuf_pkg::*;
#(
  parameter int W = LANES
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_narrow,
  input logic         cfg_bsel,
  input logic         sel_dev_n,
  input logic         sel_rank_n,
  input logic [W-1:0] d_in,
  input logic         cke_in,
  input logic         odt_in,
  input logic [W-1:0] q_a,
  input logic [W-1:0] q_b,
  input logic         cke_a,
  input logic         cke_b,
  input logic         odt_a,
  input logic         odt_b,
  input logic         cs_a,
  input logic         cs_b
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_CLEAR: assert (q_a == '0 && q_b == '0 && !cke_a && !cke_b &&
                             !odt_a && !odt_b && !cs_a && !cs_b)
        else $error("outputs not cleared in reset"); // R1
    end
  end

  AST_HOLD_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_dev_n && sel_rank_n) |=> ($stable(q_a) && $stable(q_b))) // R3
    else $error("data moved while both selects high");

  AST_LOAD_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_dev_n || !sel_rank_n) |=> (q_a == ($past(d_in) & lane_mask(cfg_narrow, cfg_bsel)))) // R4
    else $error("data not loaded while selected");

  AST_CTL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cke_a == $past(cke_in) && odt_a == $past(odt_in) && cs_a == $past(sel_dev_n))) // R5
    else $error("control pass-through mismatch");

  AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (q_a & ~lane_mask(cfg_narrow, cfg_bsel)) == '0) // R6
    else $error("inactive lane nonzero");

  AST_WIDE_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_narrow |-> (q_b == '0 && !cke_b && !odt_b && !cs_b)) // R7
    else $error("B copy active in wide mode");

  AST_NARROW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_narrow |-> (q_b == q_a && cke_b == cke_a && odt_b == odt_a && cs_b == cs_a)) // R9
    else $error("B copy differs from A copy");
endmodule

bind sbuf_cs_gated sbuf_cs_gated_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_bsel(cfg_bsel),
  .sel_dev_n(sel_dev_n), .sel_rank_n(sel_rank_n), .d_in(d_in),
  .cke_in(cke_in), .odt_in(odt_in), .q_a(q_a), .q_b(q_b),
  .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b),
  .cs_a(cs_a), .cs_b(cs_b)
);

// File: tb/sim_sbuf_cs_gated.sv
module sim_sbuf_cs_gated;
  localparam int PERIOD = 10;
  localparam int W = 25;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_narrow = 1'b0, cfg_bsel = 1'b0;
  logic         sel_dev_n = 1'b1, sel_rank_n = 1'b1;
  logic [W-1:0] d_in = '0;
  logic         cke_in = 1'b0, odt_in = 1'b0;
  logic [W-1:0] q_a, q_b;
  logic         cke_a, cke_b, odt_a, odt_b, cs_a, cs_b;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [W-1:0] qa;
    logic [W-1:0] qb;
    logic [5:0]   ctl;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [W-1:0] model_q = '0;

  always #(PERIOD/2) clk = ~clk;

  sbuf_cs_gated u0 (
    .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_bsel(cfg_bsel),
    .sel_dev_n(sel_dev_n), .sel_rank_n(sel_rank_n), .d_in(d_in),
    .cke_in(cke_in), .odt_in(odt_in), .q_a(q_a), .q_b(q_b),
    .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b),
    .cs_a(cs_a), .cs_b(cs_b)
  );

  // lane sets taken from the requirements (lane n = bit n-1)
  function automatic logic [W-1:0] req_mask(input logic narrow, input logic bsel);
    logic [W-1:0] m = '0;
    if (!narrow) begin
      m[1] = 1; m[2] = 1; m[4] = 1; m[5] = 1;
      for (int n = 8; n <= 25; n++) m[n-1] = 1;       // R6
    end else if (!bsel) begin
      m[1] = 1; m[2] = 1; m[4] = 1; m[5] = 1;
      for (int n = 8; n <= 14; n++) m[n-1] = 1;       // R8
    end else begin
      for (int n = 1; n <= 6; n++) m[n-1] = 1;        // R9
      m[7] = 1; m[8] = 1; m[9] = 1; m[11] = 1; m[12] = 1;
    end
    return m;
  endfunction

  // driver: apply one edge's inputs and push the expected outputs
  task automatic step(input logic [W-1:0] d, input logic cke, input logic odt,
                      input logic dev_n, input logic rank_n, input string tag);
    exp_t e;
    @(negedge clk);
    d_in = d; cke_in = cke; odt_in = odt; sel_dev_n = dev_n; sel_rank_n = rank_n;
    if (!(dev_n && rank_n)) model_q = d & req_mask(cfg_narrow, cfg_bsel);
    e.qa  = model_q;
    e.qb  = cfg_narrow ? model_q : '0;
    e.ctl = {dev_n, odt, cke, cfg_narrow & dev_n, cfg_narrow & odt, cfg_narrow & cke};
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare after each capturing edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      logic [5:0] act;
      e = sb.pop_front();
      act = {cs_a, odt_a, cke_a, cs_b, odt_b, cke_b};
      checks++;
      if (q_a !== e.qa || q_b !== e.qb || act !== e.ctl) begin
        errors++;
        $display("FAIL %s qa=%h qb=%h ctl=%b expected qa=%h qb=%h ctl=%b",
                 e.tag, q_a, q_b, act, e.qa, e.qb, e.ctl);
      end
    end
  end

  task automatic enter_reset(input logic narrow, input logic bsel);
    @(posedge clk);
    #3 rst_n = 1'b0;
    #1;
    checks++;
    if ({q_a, q_b, cke_a, cke_b, odt_a, odt_b, cs_a, cs_b} !== '0) begin
      errors++;
      $display("FAIL R1 async reset qa=%h qb=%h expected all zero", q_a, q_b);
    end
    cfg_narrow = narrow; cfg_bsel = bsel;
    model_q = '0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if ({q_a, q_b, cke_a, cke_b, odt_a, odt_b, cs_a, cs_b} !== '0) begin
      errors++;
      $display("FAIL R1 held reset qa=%h expected 0", q_a);
    end
    rst_n = 1'b1;
  endtask

  task automatic run_mode(input string name);
    step('1, 1, 0, 0, 1, {name, " R2 R4 all ones dev low"});
    step(25'h0AAAAAA, 0, 1, 1, 0, {name, " R4 rank low"});
    step(25'h1555555, 1, 1, 1, 1, {name, " R3 R5 frozen ctl moves"});
    step(25'h0F0F0F0, 0, 0, 1, 1, {name, " R3 frozen again"});
    step(25'h0F0F0F0, 1, 0, 0, 0, {name, " R4 both low"});
    for (int i = 0; i < 12; i++) begin
      logic [W-1:0] r;
      r = W'($urandom);
      step(r, r[0], r[1], r[2], r[3], {name, " R2 R3 R5 random"});
    end
  endtask

  initial begin
    #(PERIOD * 4000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3;
    checks++;
    if ({q_a, q_b, cke_a, cke_b, odt_a, odt_b, cs_a, cs_b} !== '0) begin
      errors++;
      $display("FAIL R1 initial reset qa=%h expected 0", q_a);
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_mode("R6 R7 wide");
    enter_reset(1'b1, 1'b0);
    run_mode("R8 R9 narrowA");
    enter_reset(1'b1, 1'b1);
    run_mode("R9 narrowB");
    enter_reset(1'b0, 1'b0);
    step('1, 1, 1, 1, 0, "R7 wide after reset");
    @(posedge clk);
    #4;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule